// File: doc/BRIEF.md
# Address-Watch Thread Wakeup Unit

This per-core unit lets each hardware thread sleep instead of spinning in a polling loop. A thread first programs a window of memory addresses to watch and marks the window valid. It then raises its suspend request, and the unit drops that thread's run enable. The unit watches the stream of write addresses that the core's memory path snoops. When a write lands inside a suspended thread's window, the unit raises that thread's run enable again on the following cycle.

A write can land in the window after the window is armed but before the thread suspends. Such a write is not lost: it is held as a pending wakeup, and the next suspend request from that thread returns at once. Window bounds are compared at cache-line granularity (64-byte lines by default). The lower bound is inclusive and the upper bound is exclusive. A single write may release any number of threads at the same time.

Top module: `thread_wake_unit`

## Requirements
- R1: After reset every `run_en` bit is 1 and no thread's window is valid, so a suspend request right after reset leaves `run_en` at 1.
- R2: A write on the configuration port (`cfg_we`=1) updates the register of thread `cfg_tid` chosen by `cfg_sel`: 0 writes the window base, 1 writes the window limit, 2 writes the control register with bit 0 as the valid flag. Selector 3 changes nothing.
- R3: When a running thread with a valid window raises `susp_req`, with no pending wakeup and no matching write in that cycle, its `run_en` is 0 from the next cycle on.
- R4: While a thread is suspended, a snooped write (`snoop_vld`=1) that falls in its window sets its `run_en` to 1 on the cycle after the write. Writes outside the window, and cycles with `snoop_vld`=0, leave it suspended.
- R5: A write matches when its line address (`snoop_addr` with the low 6 bits dropped) is at least the base's line address and below the limit's line address. The low 6 bits of base, limit and write address play no part.
- R6: A matching write seen while the thread runs with a valid window sets a pending wakeup. The next suspend request then keeps `run_en` at 1 and consumes the pending wakeup, so a second suspend with no new match does suspend.
- R7: A control-register write to a thread clears its pending wakeup.
- R8: A suspend request from a thread whose window is not valid is ignored and `run_en` stays 1.
- R9: One snooped write releases every suspended thread whose window holds it, in the same cycle.
- R10: A suspend request raised in the same cycle as a matching write keeps `run_en` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tid | input | 2 | Thread addressed by the configuration write |
| cfg_sel | input | 2 | Register select: 0 base, 1 limit, 2 control, 3 none |
| cfg_data | input | 40 | Configuration write data |
| susp_req | input | 4 | Per-thread suspend request |
| snoop_vld | input | 1 | Snooped write address is valid |
| snoop_addr | input | 40 | Snooped write byte address |
| run_en | output | 4 | Per-thread run enable, 1 while the thread may run |

## Verification
Random traffic puts writes just inside and just outside small overlapping windows. It mixes these with random configuration writes, including the unused selector, and with random suspend requests. A cycle-level reference model then has to agree on every run-enable bit, which tells a wrong boundary apart from a lost or spurious wakeup. Directed cases handle the remaining situations one at a time: the bytes on either side of both bounds with unaligned bound values, a pending wakeup followed by two suspends, a pending wakeup cancelled by a control write, a suspend request meeting a match in the same cycle, and one write that overlaps three windows. Each of these isolates one ordering rule.

// File: rtl/wake_pkg.sv
package wake_pkg;
   // Configuration register select codes
   typedef enum logic [1:0] {
      WREG_BASE  = 2'd0,
      WREG_LIMIT = 2'd1,
      WREG_CTRL  = 2'd2,
      WREG_NONE  = 2'd3
   } wreg_e;
endpackage

// File: rtl/wake_range_match.sv
module wake_range_match #(
   parameter int  LINE_W     = 34,
   parameter bit  INCL_LIMIT = 1'b0
) (
   input  logic              en,
   input  logic [LINE_W-1:0] line,
   input  logic [LINE_W-1:0] lo,
   input  logic [LINE_W-1:0] hi,
   output logic              hit
);
   logic above_lo;
   logic below_hi;

   assign above_lo = (line >= lo);

   generate
      if (INCL_LIMIT) begin : g_incl
         assign below_hi = (line <= hi);
      end else begin : g_excl
         assign below_hi = (line < hi);
      end
   endgenerate

   assign hit = en & above_lo & below_hi;
endmodule

// File: rtl/wake_thread_ctl.sv
module wake_thread_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic armed,
   input  logic susp_req,
   input  logic ctrl_wr,
   output logic run_en,
   output logic pending
);
   logic run_q;
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         if (run_q) begin
            if (susp_req && armed) begin
               run_q  <= pend_q | hit;
               pend_q <= 1'b0;
            end else if (hit) begin
               pend_q <= 1'b1;
            end
         end else if (hit) begin
            run_q  <= 1'b1;
            pend_q <= 1'b0;
         end
         if (ctrl_wr) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign run_en  = run_q;
   assign pending = pend_q;
endmodule

// File: rtl/thread_wake_unit.sv
module thread_wake_unit #(
   parameter int NUM_THREADS = 4,
   parameter int ADDR_W      = 40,
   parameter int LINE_OFS    = 6,
   parameter bit INCL_LIMIT  = 1'b0,
   localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
   localparam int LINE_W     = ADDR_W - LINE_OFS
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [TID_W-1:0]       cfg_tid,
   input  logic [1:0]             cfg_sel,
   input  logic [ADDR_W-1:0]      cfg_data,
   input  logic [NUM_THREADS-1:0] susp_req,
   input  logic                   snoop_vld,
   input  logic [ADDR_W-1:0]      snoop_addr,
   output logic [NUM_THREADS-1:0] run_en
);
   import wake_pkg::*;

   generate
      if (NUM_THREADS < 1) begin : g_bad_threads
         $error("thread_wake_unit: NUM_THREADS must be at least 1");
      end
      if (LINE_OFS < 0 || LINE_OFS >= ADDR_W) begin : g_bad_ofs
         $error("thread_wake_unit: LINE_OFS must lie below ADDR_W");
      end
   endgenerate

   wreg_e             sel;
   logic [LINE_W-1:0] snoop_line;
   logic [LINE_W-1:0] data_line;

   logic [NUM_THREADS-1:0] hit_vec;
   logic [NUM_THREADS-1:0] valid_vec;
   logic [NUM_THREADS-1:0] pend_vec;

   assign sel        = wreg_e'(cfg_sel);
   assign snoop_line = snoop_addr[ADDR_W-1:LINE_OFS];
   assign data_line  = cfg_data[ADDR_W-1:LINE_OFS];

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic [LINE_W-1:0] base_q;
      logic [LINE_W-1:0] limit_q;
      logic              valid_q;
      logic              sel_me;
      logic              ctrl_wr;

      assign sel_me  = cfg_we && (cfg_tid == TID_W'(t));
      assign ctrl_wr = sel_me && (sel == WREG_CTRL);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
            valid_q <= 1'b0;
         end else if (sel_me) begin
            unique case (sel)
               WREG_BASE:  base_q  <= data_line;
               WREG_LIMIT: limit_q <= data_line;
               WREG_CTRL:  valid_q <= cfg_data[0];
               WREG_NONE:  ;
            endcase
         end
      end

      wake_range_match #(
         .LINE_W     (LINE_W),
         .INCL_LIMIT (INCL_LIMIT)
      ) u_match (
         .en   (snoop_vld & valid_q),
         .line (snoop_line),
         .lo   (base_q),
         .hi   (limit_q),
         .hit  (hit_vec[t])
      );

      wake_thread_ctl u_ctl (
         .clk      (clk),
         .rst_n    (rst_n),
         .hit      (hit_vec[t]),
         .armed    (valid_q),
         .susp_req (susp_req[t]),
         .ctrl_wr  (ctrl_wr),
         .run_en   (run_en[t]),
         .pending  (pend_vec[t])
      );

      assign valid_vec[t] = valid_q;
   end
endmodule

// File: rtl/wake_unit_checker.sv
module wake_unit_checker #(
   parameter int NUM_THREADS = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_THREADS-1:0] susp_req,
   input logic [NUM_THREADS-1:0] run_en,
   input logic [NUM_THREADS-1:0] hit,
   input logic [NUM_THREADS-1:0] valid,
   input logic [NUM_THREADS-1:0] pending
);
   // R1: reset leaves every thread running
   p_reset_run_r1: assert property (@(posedge clk)
      !rst_n |=> (run_en == {NUM_THREADS{1'b1}}));

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
      // R3: armed suspend with nothing pending sleeps
      p_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (run_en[t] && susp_req[t] && valid[t] && !pending[t] && !hit[t])
         |=> !run_en[t]);
      // R4: a match wakes a sleeping thread next cycle
      p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_en[t] && hit[t]) |=> run_en[t]);
      // R4: without a match a sleeping thread stays asleep
      p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_en[t] && !hit[t]) |=> !run_en[t]);
      // R6: a pending wakeup makes the suspend return
      p_pend_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (run_en[t] && susp_req[t] && pending[t]) |=> run_en[t]);
      // R8: suspend without a valid window is ignored
      p_no_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (run_en[t] && !valid[t]) |=> run_en[t]);
      // R10: suspend meeting a match keeps running
      p_same_cyc_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (run_en[t] && susp_req[t] && hit[t]) |=> run_en[t]);
      // R3: run enable only falls after a suspend request
      p_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(run_en[t]) |-> $past(susp_req[t]));
   end
endmodule

bind thread_wake_unit wake_unit_checker #(.NUM_THREADS(NUM_THREADS)) u_wake_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .susp_req (susp_req),
   .run_en   (run_en),
   .hit      (hit_vec),
   .valid    (valid_vec),
   .pending  (pend_vec)
);

// File: tb/thread_wake_unit_bench.sv
module thread_wake_unit_bench;
   localparam int NT  = 4;
   localparam int AW  = 40;
   localparam int OFS = 6;
   localparam int LW  = AW - OFS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_tid = '0;
   logic [1:0]    cfg_sel = '0;
   logic [AW-1:0] cfg_data = '0;
   logic [NT-1:0] susp_req = '0;
   logic          snoop_vld = 1'b0;
   logic [AW-1:0] snoop_addr = '0;
   logic [NT-1:0] run_en;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // reference state
   logic [LW-1:0] m_base [NT];
   logic [LW-1:0] m_lim  [NT];
   logic          m_val  [NT];
   logic          m_pend [NT];
   logic          m_run  [NT];

   always #2 clk = ~clk;

   thread_wake_unit u_thread_wake_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tid(cfg_tid),
      .cfg_sel(cfg_sel), .cfg_data(cfg_data), .susp_req(susp_req),
      .snoop_vld(snoop_vld), .snoop_addr(snoop_addr), .run_en(run_en));

   function automatic bit m_hit(int t);
      logic [LW-1:0] ln;
      ln = snoop_addr[AW-1:OFS];
      return snoop_vld && m_val[t] && (ln >= m_base[t]) && (ln < m_lim[t]);
   endfunction

   task automatic model_reset();
      for (int t = 0; t < NT; t++) begin
         m_base[t] = '0; m_lim[t] = '0; m_val[t] = 1'b0;
         m_pend[t] = 1'b0; m_run[t] = 1'b1;
      end
   endtask

   task automatic model_step();
      bit h [NT];
      for (int t = 0; t < NT; t++) h[t] = m_hit(t);
      for (int t = 0; t < NT; t++) begin
         if (m_run[t]) begin
            if (susp_req[t] && m_val[t]) begin
               m_run[t] = m_pend[t] | h[t];
               m_pend[t] = 1'b0;
            end else if (h[t]) m_pend[t] = 1'b1;
         end else if (h[t]) begin
            m_run[t] = 1'b1; m_pend[t] = 1'b0;
         end
      end
      if (cfg_we) begin
         case (cfg_sel)
            2'd0: m_base[cfg_tid] = cfg_data[AW-1:OFS];
            2'd1: m_lim[cfg_tid]  = cfg_data[AW-1:OFS];
            2'd2: begin m_val[cfg_tid] = cfg_data[0]; m_pend[cfg_tid] = 1'b0; end
            default: ;
         endcase
      end
   endtask

   task automatic cmp_model(string tag);
      logic [NT-1:0] exp;
      for (int t = 0; t < NT; t++) exp[t] = m_run[t];
      checks++;
      if (run_en !== exp) begin
         errors++;
         $display("FAIL %s: run_en actual=%b expected=%b at %0t", tag, run_en, exp, $time);
      end
   endtask

   task automatic expect_run(int t, bit e, string tag);
      checks++;
      if (run_en[t] !== e) begin
         errors++;
         $display("FAIL %s: run_en[%0d] actual=%b expected=%b", tag, t, run_en[t], e);
      end
   endtask

   // inputs are set at a negedge; this clocks them in and comes back to a negedge
   task automatic tick(string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      cfg_we = 1'b0; susp_req = '0; snoop_vld = 1'b0;
      cmp_model(tag);
   endtask

   task automatic cfg(int t, int s, logic [AW-1:0] d);
      cfg_we = 1'b1; cfg_tid = 2'(t); cfg_sel = 2'(s); cfg_data = d;
      tick("R2");
   endtask

   task automatic arm(int t, logic [AW-1:0] lo, logic [AW-1:0] hi);
      cfg(t, 0, lo); cfg(t, 1, hi); cfg(t, 2, 1);
   endtask

   task automatic snoop(logic [AW-1:0] a, string tag);
      snoop_vld = 1'b1; snoop_addr = a;
      tick(tag);
   endtask

   task automatic suspend(logic [NT-1:0] m, string tag);
      susp_req = m;
      tick(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_model("R1");
      for (int t = 0; t < NT; t++) expect_run(t, 1'b1, "R1");
      suspend('1, "R1");           // nothing armed yet
      for (int t = 0; t < NT; t++) expect_run(t, 1'b1, "R8");

      // R5 boundaries with unaligned bound values
      arm(0, 40'h1010, 40'h2030);   // lines 0x40..0x7F
      suspend(4'b0001, "R3");
      expect_run(0, 1'b0, "R3");
      snoop(40'h0FFF, "R5");        // below base line
      expect_run(0, 1'b0, "R5");
      snoop(40'h2000, "R5");        // first byte of limit line: excluded
      expect_run(0, 1'b0, "R5");
      snoop_addr = 40'h1000;        // no valid strobe
      tick("R4");
      expect_run(0, 1'b0, "R4");
      snoop(40'h1000, "R5");        // base line, offset below base byte
      expect_run(0, 1'b1, "R4");
      suspend(4'b0001, "R3");
      snoop(40'h1FFF, "R5");        // last byte before limit line
      expect_run(0, 1'b1, "R5");

      // R6 pending then two suspends
      snoop(40'h1800, "R6");
      suspend(4'b0001, "R6");
      expect_run(0, 1'b1, "R6");
      suspend(4'b0001, "R6");
      expect_run(0, 1'b0, "R6");
      snoop(40'h1840, "R4");

      // R7 control write cancels pending
      snoop(40'h1800, "R7");
      cfg(0, 2, 1);
      suspend(4'b0001, "R7");
      expect_run(0, 1'b0, "R7");
      snoop(40'h1800, "R4");

      // R2 selector 3 changes nothing
      cfg(0, 3, 40'h0);
      snoop(40'h1800, "R2");        // still matches: sets pending
      suspend(4'b0001, "R2");
      expect_run(0, 1'b1, "R2");

      // R10 suspend meets match in same cycle
      susp_req = 4'b0001; snoop_vld = 1'b1; snoop_addr = 40'h1900;
      tick("R10");
      expect_run(0, 1'b1, "R10");

      // R9 one write, three windows
      arm(1, 40'h1000, 40'h3000);
      arm(2, 40'h1800, 40'h1900);
      arm(3, 40'h4000, 40'h5000);
      suspend(4'b1111, "R3");
      for (int t = 0; t < NT; t++) expect_run(t, 1'b0, "R3");
      snoop(40'h1820, "R9");
      expect_run(0, 1'b1, "R9");
      expect_run(1, 1'b1, "R9");
      expect_run(2, 1'b1, "R9");
      expect_run(3, 1'b0, "R9");
      snoop(40'h4000, "R4");
      expect_run(3, 1'b1, "R4");

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(99) < 15) begin
            cfg_we   = 1'b1;
            cfg_tid  = 2'($urandom_range(3));
            cfg_sel  = 2'($urandom_range(3));
            cfg_data = AW'($urandom_range(16'h3FFF));
            if (cfg_sel == 2'd2) cfg_data[0] = ($urandom_range(99) < 85);
         end
         for (int t = 0; t < NT; t++) susp_req[t] = ($urandom_range(99) < 12);
         snoop_vld  = ($urandom_range(99) < 40);
         snoop_addr = AW'($urandom_range(16'h3FFF));
         tick("R4 random");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule